// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache placed between a word-wide processor load/store port and a memory port that moves whole blocks. It is two-way set associative, and each way has its own tag comparator. A hit is answered in the same cycle the request is seen. Stores update only lines that already hit and mark them dirty. Every line belongs to exactly one set, and each set keeps one replacement bit that names the way used less recently.

On a miss the block issues one memory read for the whole block. If the line it replaces is dirty, that line is first copied into a one-entry victim buffer. The refill goes to memory first, so the processor is released as soon as the new block arrives, and the parked victim is written back afterwards while the processor runs on. A load to the parked block is served from the buffer. A miss that needs the memory port while the buffer still holds data waits until the buffer has drained.

A flush request walks every line, writes back each valid dirty line and marks it clean. The lines stay valid.

Top module: `wb2_cache`

## Requirements
- R1: After reset every line is invalid, no line is dirty and every replacement bit is 0. With no request present, `cpu_stall`, `cpu_ack`, `mem_req` and `flush_busy` are all low.
- R2: Address bits [3:2] select the word in a block, bits [7:4] select one of 16 sets, and bits [31:8] form the tag. Bits [1:0] are ignored. A hit raises `cpu_ack` in the same cycle as the request, with the selected word on `cpu_rdata`.
- R3: Two blocks with the same set index and different tags are held at the same time, and each then hits.
- R4: On a miss, an invalid way is filled first, way 0 before way 1. When both ways are valid, the way not most recently hit is replaced.
- R5: A store writes the cache only on a tag hit, and it marks the line dirty. A store miss first refills the block and then writes the word.
- R6: A refill is a single read request (`mem_we`=0) at the block-aligned address. Word k of the block is carried on `mem_rdata` bits [32k+31:32k]. A refilled line starts clean.
- R7: A dirty victim is written back as a whole block in one write request, and only after the refill read has been issued. A clean victim causes no memory write.
- R8: Once `mem_req` is raised, `mem_addr`, `mem_we` and `mem_wdata` hold steady until the cycle in which `mem_ack` is high.
- R9: A load to a block held in the victim buffer is answered from the buffer in the same cycle, with no memory request.
- R10: A miss that occurs while the victim buffer still holds an unwritten block stalls. Its refill request is issued only after the buffer's write has been acknowledged.
- R11: A one-cycle `flush_req` raises `flush_busy` on the next clock edge. Every valid dirty line is written back once. `flush_busy` falls only after the last write has been acknowledged. Afterwards the lines are valid and clean, so a second flush writes nothing.
- R12: A miss costs the hit time plus the refill. The access is acknowledged in the cycle after the refill's `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_ack is high |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending but not completed |
| flush_req | input | 1 | Start writing back all dirty lines |
| flush_busy | output | 1 | Flush in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 128 | Block being written back |
| mem_rdata | input | 128 | Block returned by a read |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |

## Verification
A hit is due in the sample taken just after the falling edge at which the request is driven. A clean miss against a memory that answers after L+1 falling edges is due L+2 samples later. The bench counts those samples and compares the count against that arithmetic value. Accesses that queue behind a draining victim must take longer than a clean miss. Their memory transactions must appear in the log in the order read new block, write victim, read next block. The write-back of a victim is checked a fixed number of idle cycles after the processor is released. Flush completion is checked at the sample where `flush_busy` is first seen low.

// File: rtl/wb2_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-way write-back cache.
package wb2_pkg;
    // Controller states: serve/idle, refill, flush walk, flush drain.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_FDRAIN = 2'd3
    } wb2_state_t;
endpackage

// File: rtl/wb2_ways.sv
`timescale 1ns/1ps
// wb2_ways: tag, state and data storage for both ways, plus one tag
// comparator per way.
// Assumes that at most one of fill_en, st_en and clean_en addresses a given
// way in any cycle, and that all of them act on the set chosen by idx.
module wb2_ways #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 24,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int BLK_W = WORD_W * WORDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic [1:0]                 hit_vec,
    output logic [1:0]                 line_valid,
    output logic [1:0]                 line_dirty,
    output logic [1:0][TAG_W-1:0]      line_tag,
    output logic [1:0][BLK_W-1:0]      line_data,
    input  logic                       fill_en,
    input  logic                       fill_way,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic [BLK_W-1:0]           fill_data,
    input  logic                       st_en,
    input  logic                       st_way,
    input  logic [OFF_W-1:0]           st_word,
    input  logic [WORD_W-1:0]          st_data,
    input  logic                       clean_en,
    input  logic                       clean_way
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        localparam logic WAY_ID = 1'(w);
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q  [SETS];
        logic [BLK_W-1:0] data_q [SETS];

        // Purpose: track valid and dirty per line; a fill cleans, a store dirties.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (fill_en && fill_way == WAY_ID) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end else if (st_en && st_way == WAY_ID) begin
                dirty_q[idx] <= 1'b1;
            end else if (clean_en && clean_way == WAY_ID) begin
                dirty_q[idx] <= 1'b0;
            end
        end

        // Purpose: write the tag and block on a fill, or one word on a store hit.
        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_ID) begin
                tag_q[idx]  <= fill_tag;
                data_q[idx] <= fill_data;
            end else if (st_en && st_way == WAY_ID) begin
                for (int k = 0; k < WORDS; k++) begin
                    if (st_word == OFF_W'(k))
                        data_q[idx][k*WORD_W +: WORD_W] <= st_data;
                end
            end
        end

        assign line_valid[w] = valid_q[idx];
        assign line_dirty[w] = dirty_q[idx];
        assign line_tag[w]   = tag_q[idx];
        assign line_data[w]  = data_q[idx];
        assign hit_vec[w]    = valid_q[idx] && (tag_q[idx] == cmp_tag);

        // R6: a refilled line is valid and clean on the next cycle
        a_r6_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && fill_way == WAY_ID) |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));
    end

    // R3: a block is never present in both ways of a set
    a_r3_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5: the controller writes store data only into a way whose tag hits
    a_r5_store_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> hit_vec[st_way]);

endmodule

// File: rtl/wb2_lru.sv
`timescale 1ns/1ps
// wb2_lru: one replacement bit per set that names the way to evict next.
// Assumes that a touch marks the given way as most recently used.
module wb2_lru #(
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim_way
);
    logic [SETS-1:0] lru_q;

    // Purpose: point the set's bit at the way that was not just used.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (touch_en)
            lru_q[idx] <= ~touch_way;
    end

    assign victim_way = lru_q[idx];

    // R4: after a hit the set's replacement bit names the other way
    a_r4_points_away: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (lru_q[$past(idx)] != $past(touch_way)));
endmodule

// File: rtl/wb2_victim.sv
`timescale 1ns/1ps
// wb2_victim: single-entry holding register for a dirty block awaiting
// write-back.
// Assumes that the controller loads it only while it is empty and clears it
// on the memory acknowledge.
module wb2_victim #(
    parameter int BA_W  = 28,
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [BA_W-1:0]  load_addr,
    input  logic [BLK_W-1:0] load_data,
    input  logic             done_en,
    output logic             vb_valid,
    output logic [BA_W-1:0]  vb_addr,
    output logic [BLK_W-1:0] vb_data
);
    // Purpose: occupancy flag of the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vb_valid <= 1'b0;
        else if (load_en)
            vb_valid <= 1'b1;
        else if (done_en)
            vb_valid <= 1'b0;
    end

    // Purpose: capture the evicted block and its block address.
    always_ff @(posedge clk) begin
        if (load_en) begin
            vb_addr <= load_addr;
            vb_data <= load_data;
        end
    end

    // R10: an unwritten victim is never overwritten by a new eviction
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !vb_valid);

    // R7: a parked victim keeps its address and data until written
    a_r7_victim_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_valid && !done_en) |=> (vb_valid && $stable(vb_addr) && $stable(vb_data)));
endmodule

// File: rtl/wb2_cache.sv
`timescale 1ns/1ps
// wb2_cache: two-way set-associative write-back data cache with a one-entry
// victim buffer and a flush walk.
// Assumes that the processor holds cpu_req, cpu_we, cpu_addr and cpu_wdata
// steady until cpu_ack, and that memory answers each request with a
// one-cycle mem_ack.
module wb2_cache
    import wb2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    localparam int BYTE_W = $clog2(WORD_W / 8),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
    localparam int BA_W   = TAG_W + IDX_W,
    localparam int BLK_W  = WORD_W * WORDS,
    localparam int LINES  = SETS * 2,
    localparam int PTR_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_stall,
    input  logic              flush_req,
    output logic              flush_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_ack
);
    // Address fields
    logic [TAG_W-1:0] cpu_tag;
    logic [IDX_W-1:0] cpu_idx;
    logic [OFF_W-1:0] cpu_off;
    logic [BA_W-1:0]  cpu_blk;
    logic             unused_byte;
    assign cpu_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx     = cpu_addr[BYTE_W+OFF_W +: IDX_W];
    assign cpu_off     = cpu_addr[BYTE_W +: OFF_W];
    assign cpu_blk     = cpu_addr[ADDR_W-1 -: BA_W];
    assign unused_byte = ^cpu_addr[BYTE_W-1:0];

    wb2_state_t       state_q;
    logic             fill_way_q;
    logic [BA_W-1:0]  fill_blk_q;
    logic [PTR_W-1:0] ptr_q;

    logic [IDX_W-1:0]         idx_sel;
    logic [1:0]               hit_vec, line_valid, line_dirty;
    logic [1:0][TAG_W-1:0]    line_tag;
    logic [1:0][BLK_W-1:0]    line_data;
    logic                     lru_victim;
    logic                     vb_valid;
    logic [BA_W-1:0]          vb_addr;
    logic [BLK_W-1:0]         vb_data;

    logic in_idle, serve, hit_any, hit_way, vb_match, miss_go;
    logic vict_way, miss_evict, fl_way, fl_dirty, fl_take, fl_step;
    logic fill_active, drain_active, fill_en, vb_done, vb_load;
    logic [BA_W-1:0]  vb_load_addr;
    logic [BLK_W-1:0] vb_load_data, sel_blk;

    // Purpose: pick the set the storage looks at in each state.
    always_comb begin
        case (state_q)
            ST_FILL:  idx_sel = fill_blk_q[IDX_W-1:0];
            ST_FLUSH: idx_sel = ptr_q[PTR_W-1:1];
            default:  idx_sel = cpu_idx;
        endcase
    end

    assign in_idle  = (state_q == ST_IDLE);
    assign serve    = in_idle && cpu_req && !flush_req;
    assign hit_any  = |hit_vec;
    assign hit_way  = hit_vec[1];
    assign vb_match = vb_valid && (vb_addr == cpu_blk) && !cpu_we;
    assign cpu_ack  = serve && (hit_any || vb_match);
    assign cpu_stall = cpu_req && !cpu_ack;
    assign miss_go  = serve && !hit_any && !vb_match && !vb_valid;

    // Victim choice: invalid way 0, then invalid way 1, then the replacement bit
    assign vict_way   = !line_valid[0] ? 1'b0 : (!line_valid[1] ? 1'b1 : lru_victim);
    assign miss_evict = miss_go && line_valid[vict_way] && line_dirty[vict_way];

    // Flush walk over (set, way) pairs
    assign fl_way   = ptr_q[0];
    assign fl_dirty = line_valid[fl_way] && line_dirty[fl_way];
    assign fl_take  = (state_q == ST_FLUSH) && fl_dirty && !vb_valid;
    assign fl_step  = (state_q == ST_FLUSH) && (!fl_dirty || !vb_valid);

    assign vb_load      = miss_evict || fl_take;
    assign vb_load_addr = (state_q == ST_FLUSH) ? {line_tag[fl_way], ptr_q[PTR_W-1:1]}
                                                : {line_tag[vict_way], cpu_idx};
    assign vb_load_data = (state_q == ST_FLUSH) ? line_data[fl_way] : line_data[vict_way];

    // Memory port: refill has priority, the victim drains otherwise
    assign fill_active  = (state_q == ST_FILL);
    assign drain_active = !fill_active && vb_valid;
    assign mem_req   = fill_active || drain_active;
    assign mem_we    = !fill_active;
    assign mem_addr  = {(fill_active ? fill_blk_q : vb_addr), {(OFF_W+BYTE_W){1'b0}}};
    assign mem_wdata = vb_data;
    assign fill_en   = fill_active && mem_ack;
    assign vb_done   = drain_active && mem_ack;
    assign flush_busy = (state_q == ST_FLUSH) || (state_q == ST_FDRAIN);

    // Purpose: select the load word from the hitting way or the victim buffer.
    assign sel_blk = hit_any ? line_data[hit_way] : vb_data;
    always_comb begin
        cpu_rdata = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (cpu_off == OFF_W'(k))
                cpu_rdata = sel_blk[k*WORD_W +: WORD_W];
        end
    end

    wb2_ways #(.SETS(SETS), .TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_ways (
        .clk(clk), .rst_n(rst_n), .idx(idx_sel), .cmp_tag(cpu_tag),
        .hit_vec(hit_vec), .line_valid(line_valid), .line_dirty(line_dirty),
        .line_tag(line_tag), .line_data(line_data),
        .fill_en(fill_en), .fill_way(fill_way_q),
        .fill_tag(fill_blk_q[BA_W-1:IDX_W]), .fill_data(mem_rdata),
        .st_en(cpu_ack && cpu_we), .st_way(hit_way), .st_word(cpu_off), .st_data(cpu_wdata),
        .clean_en(fl_take), .clean_way(fl_way)
    );

    wb2_lru #(.SETS(SETS)) u_lru (
        .clk(clk), .rst_n(rst_n), .idx(idx_sel),
        .touch_en(cpu_ack && hit_any), .touch_way(hit_way), .victim_way(lru_victim)
    );

    wb2_victim #(.BA_W(BA_W), .BLK_W(BLK_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .load_en(vb_load), .load_addr(vb_load_addr),
        .load_data(vb_load_data), .done_en(vb_done),
        .vb_valid(vb_valid), .vb_addr(vb_addr), .vb_data(vb_data)
    );

    // Purpose: controller sequencing for refill and flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fill_way_q <= 1'b0;
            fill_blk_q <= '0;
            ptr_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (flush_req) begin
                        state_q <= ST_FLUSH;
                        ptr_q   <= '0;
                    end else if (miss_go) begin
                        state_q    <= ST_FILL;
                        fill_way_q <= vict_way;
                        fill_blk_q <= cpu_blk;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) state_q <= ST_IDLE;
                end
                ST_FLUSH: begin
                    if (fl_step) begin
                        if (ptr_q == PTR_W'(LINES - 1)) state_q <= ST_FDRAIN;
                        else                            ptr_q   <= ptr_q + 1'b1;
                    end
                end
                default: begin
                    if (!vb_valid) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R8: an outstanding memory request keeps its fields until acknowledged
    a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R12: the cycle after a refill completes, a held request is acknowledged
    a_r12_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_active && mem_ack && cpu_req) |=> (cpu_ack || flush_req || !cpu_req));

endmodule

// File: tb/wb2_cache_tb.sv
`timescale 1ns/1ps
module wb2_cache_tb;
    localparam int LAT      = 3;
    localparam int MISS_CYC = LAT + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ack, cpu_stall;
    logic         flush_req = 1'b0;
    logic         flush_busy;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    always #2 clk = ~clk;

    wb2_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .cpu_stall(cpu_stall), .flush_req(flush_req),
        .flush_busy(flush_busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    int n_chk = 0, n_err = 0;
    int n_rd = 0, n_wr = 0, hold_bad = 0, cnt = 0, log_n = 0;
    logic [127:0] mem [256];
    logic [31:0]  log_addr [64];
    logic         log_we [64];
    logic [31:0]  held_addr;
    logic         held_we;
    logic [31:0]  shadow [1024];

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Block memory responder: acknowledges on the (LAT+1)th falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt == 0) begin
                held_addr = mem_addr;
                held_we = mem_we;
            end else if (mem_addr != held_addr || mem_we != held_we) begin
                hold_bad++;
            end
            if (cnt == LAT) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:4]] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[11:4]];
                    n_rd++;
                end
                if (log_n < 64) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n] = mem_we;
                    log_n++;
                end
                cnt = 0;
            end else begin
                cnt++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_req = 1'b0;
        flush_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        waits = 0;
        #1;
        while (!cpu_ack && waits < 2000) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        #1;
        chk("R11 busy after request", 128'(flush_busy), 128'(1));
        while (flush_busy) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int w, base, wr0, rd0, mism;
        for (int b = 0; b < 256; b++)
            for (int k = 0; k < 4; k++)
                mem[b][32*k +: 32] = init_word({20'd0, 8'(b), 2'(k), 2'b00});

        // R1: idle outputs after reset
        do_reset();
        chk("R1 stall idle", 128'(cpu_stall), 128'(0));
        chk("R1 ack idle", 128'(cpu_ack), 128'(0));
        chk("R1 mem_req idle", 128'(mem_req), 128'(0));
        chk("R1 flush_busy idle", 128'(flush_busy), 128'(0));

        // R2/R6/R12: first access is a clean miss
        base = log_n; rd0 = n_rd;
        acc(1'b0, 32'h000, 32'h0, rd, w);
        chk("R12 clean miss latency", 128'(w), 128'(MISS_CYC));
        chk("R2 miss data", 128'(rd), 128'(init_word(32'h000)));
        chk("R6 one read per miss", 128'(n_rd - rd0), 128'(1));
        chk("R6 read aligned", {95'd0, log_we[base], log_addr[base]}, 128'(32'h000));
        acc(1'b0, 32'h00B, 32'h0, rd, w);
        chk("R2 hit same cycle", 128'(w), 128'(0));
        chk("R2 word select", 128'(rd), 128'(init_word(32'h008)));

        // R3/R4: second way, then LRU choice
        acc(1'b0, 32'h100, 32'h0, rd, w);
        chk("R3 other tag miss", 128'(w), 128'(MISS_CYC));
        acc(1'b0, 32'h004, 32'h0, rd, w);
        chk("R3 first block still hits", 128'(w), 128'(0));
        acc(1'b0, 32'h104, 32'h0, rd, w);
        chk("R3 second block hits", 128'(w), 128'(0));
        chk("R3 second block data", 128'(rd), 128'(init_word(32'h104)));
        acc(1'b0, 32'h000, 32'h0, rd, w);
        acc(1'b0, 32'h200, 32'h0, rd, w);
        chk("R4 third tag misses", 128'(w), 128'(MISS_CYC));
        acc(1'b0, 32'h00C, 32'h0, rd, w);
        chk("R4 recently hit way kept", 128'(w), 128'(0));
        acc(1'b0, 32'h100, 32'h0, rd, w);
        chk("R4 less recent way replaced", 128'(w), 128'(MISS_CYC));
        idle(10);
        chk("R7 clean victims not written", 128'(n_wr), 128'(0));

        // R5/R7/R9/R10: dirty eviction through the victim buffer
        do_reset();
        wr0 = n_wr;
        acc(1'b1, 32'h014, 32'hD00DF00D, rd, w);
        chk("R5 store miss refills", 128'(w), 128'(MISS_CYC));
        chk("R5 no write on store", 128'(n_wr - wr0), 128'(0));
        acc(1'b0, 32'h014, 32'h0, rd, w);
        chk("R5 store visible", 128'(rd), 128'(32'hD00DF00D));
        chk("R5 load hit after store", 128'(w), 128'(0));
        acc(1'b0, 32'h110, 32'h0, rd, w);
        base = log_n;
        acc(1'b0, 32'h210, 32'h0, rd, w);
        chk("R7 refill first on dirty miss", 128'(w), 128'(MISS_CYC));
        rd0 = n_rd;
        acc(1'b0, 32'h014, 32'h0, rd, w);
        chk("R9 buffered victim hit", 128'(w), 128'(0));
        chk("R9 buffered victim data", 128'(rd), 128'(32'hD00DF00D));
        chk("R9 no read for buffer hit", 128'(n_rd - rd0), 128'(0));
        acc(1'b0, 32'h310, 32'h0, rd, w);
        chk("R10 miss waits for drain", 128'(w > MISS_CYC), 128'(1));
        chk("R7 log read new block", {95'd0, log_we[base], log_addr[base]}, 128'(32'h210));
        chk("R7 log victim write", {95'd0, log_we[base+1], log_addr[base+1]},
            {95'd0, 1'b1, 32'h010});
        chk("R10 log refill after drain", {95'd0, log_we[base+2], log_addr[base+2]},
            128'(32'h310));
        idle(10);
        chk("R7 clean victim discarded", 128'(n_wr - wr0), 128'(1));
        chk("R7 whole block written",
            mem[8'h01],
            {init_word(32'h01C), init_word(32'h018), 32'hD00DF00D, init_word(32'h010)});

        // R11: flush writes dirty lines once
        do_reset();
        wr0 = n_wr;
        acc(1'b1, 32'h020, 32'hA1A1A1A1, rd, w);
        acc(1'b1, 32'h034, 32'hA2A2A2A2, rd, w);
        acc(1'b1, 32'h128, 32'hA3A3A3A3, rd, w);
        acc(1'b0, 32'h040, 32'h0, rd, w);
        do_flush();
        chk("R11 dirty lines written", 128'(n_wr - wr0), 128'(3));
        chk("R11 line 0x020", 128'(mem[8'h02][31:0]), 128'(32'hA1A1A1A1));
        chk("R11 line 0x034", 128'(mem[8'h03][63:32]), 128'(32'hA2A2A2A2));
        chk("R11 line 0x128", 128'(mem[8'h12][95:64]), 128'(32'hA3A3A3A3));
        do_flush();
        chk("R11 second flush writes nothing", 128'(n_wr - wr0), 128'(3));
        acc(1'b0, 32'h020, 32'h0, rd, w);
        chk("R11 line stays valid", 128'(w), 128'(0));
        chk("R11 line data kept", 128'(rd), 128'(32'hA1A1A1A1));

        // Sweep: mixed loads/stores over 16 sets and 5 tags, checked against a shadow
        do_reset();
        for (int b = 0; b < 256; b++)
            for (int k = 0; k < 4; k++)
                shadow[b*4 + k] = mem[b][32*k +: 32];
        for (int k = 0; k < 200; k++) begin
            logic [31:0] a, wd;
            a  = {20'd0, 4'((k * 7) % 5), 4'((k * 3) % 16), 2'(k % 4), 2'b00};
            wd = 32'(k) * 32'h01010101 + 32'h1234;
            if (k % 3 == 0) begin
                acc(1'b1, a, wd, rd, w);
                shadow[a[11:2]] = wd;
            end else begin
                acc(1'b0, a, 32'h0, rd, w);
                chk("R5 R7 sweep load data", 128'(rd), 128'(shadow[a[11:2]]));
            end
        end
        do_flush();
        mism = 0;
        for (int b = 0; b < 256; b++)
            for (int k = 0; k < 4; k++)
                if (mem[b][32*k +: 32] !== shadow[b*4 + k]) mism++;
        chk("R7 R11 memory matches after flush", 128'(mism), 128'(0));
        chk("R8 request fields held", 128'(hold_bad), 128'(0));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule